// File: doc/BRIEF.md
# DDR3 Write Leveling Sequencer

This block runs the write-leveling sweep for a DDR3 controller with nine independently aligned byte lanes. Software selects the leveling operation with a 2-bit mode field, waits for the ready flag, raises the request bit and then polls the done flag. While a run is active, the block steps one shared trial delay code from zero up to its maximum. The DQS delay line of every lane follows this code. After each new code the block waits a programmable number of settle cycles and then fires a single DQS pulse. In the cycle after the pulse it samples the feedback bit that each DRAM byte lane returns in leveling mode.

Each lane records the first trial code at which its feedback reads 1 after an earlier step read 0. That code is the point where the strobe edge crosses the clock edge, and software later programs it as the lane's write-DQS delay. A lane that never shows a 0-to-1 change during the sweep is flagged with an error bit, and the run still completes. Mode-register commands, the physical delay line and every other leveling kind live outside this block and appear only as ports.

Top module: `wlvl_seq`

## Requirements
- R1: After reset, `rdy_o`, `done_o`, `dqs_pulse_o`, all `lane_err_o` bits, all `lane_dly_o` fields and `trial_dly_o` are 0.
- R2: `rdy_o` is 1 only when the sequencer is idle, `init_done_i` is 1 and `mode_i` equals 2'b01 (write leveling). Otherwise it is 0.
- R3: A request is acted on only while `rdy_o` is 1. With mode 2'b00, 2'b10 (gate leveling, handled elsewhere) or 2'b11 (read leveling, unsupported), or with `init_done_i` low, a held request produces no DQS pulse and no done.
- R4: An accepted run presents trial codes 0, 1, ..., 2^DW-1 in order, with exactly one DQS pulse per code. `trial_dly_o` is 0 in the cycle after acceptance.
- R5: `trial_dly_o` is stable for at least settle+1 cycles before its pulse. Each pulse lasts one cycle, and consecutive pulses are exactly settle+3 cycles apart, where settle is the `settle_i` value latched at acceptance.
- R6: Feedback is sampled in the cycle after each pulse. Lane n's result field (`lane_dly_o[n*DW +: DW]`) holds the first code whose sample is 1 when an earlier code of the same run sampled 0.
- R7: A lane with no 0-to-1 change in the sweep ends with its error bit at 1 and its result field at 0. Done is still raised.
- R8: `done_o` stays 1 while `req_i` remains 1. In the cycle after `req_i` is seen low, `done_o` falls and `rdy_o` returns if R2 allows.
- R9: Dropping and raising `req_i` during a run has no effect: the sweep neither restarts nor stops, and the results are unchanged.
- R10: `rdy_o` is 0 from the cycle after acceptance until done has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Controller initialization complete |
| mode_i | input | 2 | Leveling mode field (2'b01 = write leveling) |
| req_i | input | 1 | Leveling request bit |
| settle_i | input | SW | Settle cycles after each trial code change |
| rdy_o | output | 1 | Request may be accepted |
| done_o | output | 1 | Run finished, held until request cleared |
| trial_dly_o | output | DW | Common trial DQS delay code to the delay lines |
| dqs_pulse_o | output | 1 | Single-cycle leveling DQS pulse |
| fb_i | input | LANES | Per-lane DQ feedback from DRAM |
| lane_dly_o | output | LANES*DW | Per-lane locked delay codes, lane n at [n*DW +: DW] |
| lane_err_o | output | LANES | Per-lane no-transition error flags |

## Verification
A wrong sweep counter or settle counter shows up on the first pulse gap or the first pulse code, within a few cycles of acceptance. A per-lane lock slice that latches too early, too late or not at all is only visible when done rises, as a wrong result field or error bit. For that reason, every run is checked against a bench-computed lock point for all nine lanes, using feedback patterns that include leading ones, constant ones and constant zeros. A handshake fault, such as an unsupported mode starting a sweep or done not being held, appears at `dqs_pulse_o`, `rdy_o` or `done_o` within one cycle of the triggering input.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PULSE,
    ST_SAMPLE,
    ST_DONE
  } wlvl_state_e;

  localparam logic [1:0] MODE_WRLVL = 2'b01;
endpackage

// File: rtl/wlvl_rst_sync.sv
module wlvl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wlvl_ctrl.sv
module wlvl_ctrl
  import wlvl_pkg::*;
#(
  parameter int DW = 5,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_done_i,
  input  logic [1:0]    mode_i,
  input  logic          req_i,
  input  logic [SW-1:0] settle_i,
  output logic          rdy_o,
  output logic          done_o,
  output logic          pulse_o,
  output logic [DW-1:0] code_o,
  output logic          clr_o,
  output logic          smp_o,
  output logic          last_o
);
  localparam logic [DW-1:0] CODE_MAX = {DW{1'b1}};

  wlvl_state_e   state_q, state_d;
  logic [DW-1:0] code_q, code_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] settle_q;
  logic          accept;
  logic          code_en, cnt_en;

  assign rdy_o   = (state_q == ST_IDLE) && init_done_i && (mode_i == MODE_WRLVL);
  assign accept  = rdy_o && req_i;
  assign last_o  = (code_q == CODE_MAX);
  assign done_o  = (state_q == ST_DONE);
  assign pulse_o = (state_q == ST_PULSE);
  assign smp_o   = (state_q == ST_SAMPLE);
  assign clr_o   = accept;
  assign code_o  = code_q;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETTLE;
          code_d  = '0;
          cnt_d   = settle_i;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) state_d = ST_PULSE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_PULSE:  state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (last_o) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_SETTLE;
          code_d  = code_q + 1'b1;
          cnt_d   = settle_q;
        end
      end
      ST_DONE: begin
        if (!req_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign code_en = accept || (smp_o && !last_o);
  assign cnt_en  = accept || (state_q == ST_SETTLE) || smp_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      settle_q <= '0;
    else if (accept) settle_q <= settle_i;
  end
endmodule

// File: rtl/wlvl_lane.sv
module wlvl_lane #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic          last_i,
  input  logic [DW-1:0] code_i,
  input  logic          fb_i,
  output logic [DW-1:0] res_o,
  output logic          err_o
);
  logic          seen0_q, seen0_d;
  logic          lock_q, lock_d;
  logic [DW-1:0] res_q, res_d;
  logic          err_q, err_d;
  logic          en;

  assign en = clr_i || smp_i;

  always_comb begin
    seen0_d = seen0_q;
    lock_d  = lock_q;
    res_d   = res_q;
    err_d   = err_q;
    if (clr_i) begin
      seen0_d = 1'b0;
      lock_d  = 1'b0;
      res_d   = '0;
      err_d   = 1'b0;
    end else if (smp_i) begin
      if (!lock_q) begin
        if (!fb_i) begin
          seen0_d = 1'b1;
        end else if (seen0_q) begin
          lock_d = 1'b1;
          res_d  = code_i;
        end
      end
      if (last_i) err_d = !lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen0_q <= 1'b0;
      lock_q  <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else if (en) begin
      seen0_q <= seen0_d;
      lock_q  <= lock_d;
      res_q   <= res_d;
      err_q   <= err_d;
    end
  end

  assign res_o = res_q;
  assign err_o = err_q;
endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq #(
  parameter int LANES = 9,
  parameter int DW    = 5,
  parameter int SW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_done_i,
  input  logic [1:0]          mode_i,
  input  logic                req_i,
  input  logic [SW-1:0]       settle_i,
  output logic                rdy_o,
  output logic                done_o,
  output logic [DW-1:0]       trial_dly_o,
  output logic                dqs_pulse_o,
  input  logic [LANES-1:0]    fb_i,
  output logic [LANES*DW-1:0] lane_dly_o,
  output logic [LANES-1:0]    lane_err_o
);
  logic rst_core_n;
  logic clr, smp, last;

  wlvl_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  wlvl_ctrl #(.DW(DW), .SW(SW)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .init_done_i (init_done_i),
    .mode_i      (mode_i),
    .req_i       (req_i),
    .settle_i    (settle_i),
    .rdy_o       (rdy_o),
    .done_o      (done_o),
    .pulse_o     (dqs_pulse_o),
    .code_o      (trial_dly_o),
    .clr_o       (clr),
    .smp_o       (smp),
    .last_o      (last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wlvl_lane #(.DW(DW)) i_lane (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .clr_i  (clr),
      .smp_i  (smp),
      .last_i (last),
      .code_i (trial_dly_o),
      .fb_i   (fb_i[g]),
      .res_o  (lane_dly_o[g*DW +: DW]),
      .err_o  (lane_err_o[g])
    );
  end
endmodule

// File: rtl/wlvl_seq_chk.sv
module wlvl_seq_chk #(
  parameter int DW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_done_i,
  input logic [1:0]    mode_i,
  input logic          req_i,
  input logic          rdy_o,
  input logic          done_o,
  input logic          dqs_pulse_o,
  input logic [DW-1:0] trial_dly_o
);
  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (init_done_i && mode_i == 2'b01));

  p_start_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && req_i) |=> (trial_dly_o == '0 && !rdy_o));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse_o |=> !dqs_pulse_o);

  p_code_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse_o |-> $stable(trial_dly_o));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_i) |=> done_o);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!rdy_o && !dqs_pulse_o));
endmodule

bind wlvl_seq wlvl_seq_chk #(.DW(DW)) i_wlvl_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_done_i (init_done_i),
  .mode_i      (mode_i),
  .req_i       (req_i),
  .rdy_o       (rdy_o),
  .done_o      (done_o),
  .dqs_pulse_o (dqs_pulse_o),
  .trial_dly_o (trial_dly_o)
);

// File: tb/test_wlvl_seq.sv
`timescale 1ns/1ps
module test_wlvl_seq;
  localparam int LANES = 9;
  localparam int DW    = 5;
  localparam int SW    = 8;
  localparam int NCODE = 1 << DW;

  logic                clk;
  logic                rst_n;
  logic                init_done_i;
  logic [1:0]          mode_i;
  logic                req_i;
  logic [SW-1:0]       settle_i;
  logic                rdy_o, done_o, dqs_pulse_o;
  logic [DW-1:0]       trial_dly_o;
  logic [LANES-1:0]    fb_i;
  logic [LANES*DW-1:0] lane_dly_o;
  logic [LANES-1:0]    lane_err_o;

  int n_chk, n_fail;
  int glo [LANES];
  int thr [LANES];
  int pulse_cnt, gap, cur_settle, cycles;
  bit mon_on;

  wlvl_seq #(.LANES(LANES), .DW(DW), .SW(SW)) i_wlvl_seq (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // DRAM feedback model: ones below glo, zeros up to thr, ones from thr on
  always_comb begin
    for (int l = 0; l < LANES; l++)
      fb_i[l] = (int'(trial_dly_o) < glo[l]) || (int'(trial_dly_o) >= thr[l]);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lock(input int l);
    bit z = 0;
    for (int c = 0; c < NCODE; c++) begin
      bit f = (c < glo[l]) || (c >= thr[l]);
      if (!f) z = 1;
      else if (z) return c;
    end
    return -1;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (mon_on) begin
      gap++;
      if (dqs_pulse_o) begin
        check(int'(trial_dly_o) == pulse_cnt, "R4 pulse code", int'(trial_dly_o), pulse_cnt);
        if (pulse_cnt > 0)
          check(gap == cur_settle + 3, "R5 pulse spacing", gap, cur_settle + 3);
        pulse_cnt++;
        gap = 0;
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lanes_random();
    for (int l = 0; l < LANES; l++) begin
      int k = int'($urandom % 8);
      if (k == 0) begin
        glo[l] = int'($urandom % NCODE); thr[l] = glo[l];
      end else if (k == 1) begin
        glo[l] = 0; thr[l] = NCODE + 5;
      end else begin
        glo[l] = int'($urandom % 4);
        thr[l] = glo[l] + 1 + int'($urandom % (NCODE - 1 - glo[l]));
      end
    end
  endtask

  task automatic run_once(input int settle, input bit poke);
    int w;
    settle_i = SW'(settle); cur_settle = settle;
    mode_i = 2'b01; init_done_i = 1'b1;
    @(negedge clk);
    check(rdy_o == 1'b1, "R2 ready with mode 01", rdy_o, 1);
    pulse_cnt = 0; gap = 0; mon_on = 1;
    req_i = 1'b1;
    @(negedge clk);
    check(rdy_o == 1'b0, "R10 ready low after accept", rdy_o, 0);
    if (poke) begin
      wait_cyc(20);
      req_i = 1'b0; wait_cyc(2); req_i = 1'b1;
      check(done_o == 1'b0, "R9 no early done", done_o, 0);
    end
    w = 0;
    while (!done_o && w < 5000) begin @(negedge clk); w++; end
    mon_on = 0;
    check(done_o == 1'b1, "R7 done raised", done_o, 1);
    check(pulse_cnt == NCODE, poke ? "R9 full sweep" : "R4 pulse count", pulse_cnt, NCODE);
    for (int l = 0; l < LANES; l++) begin
      int e = exp_lock(l);
      int r = int'(lane_dly_o[l*DW +: DW]);
      if (e < 0) begin
        check(lane_err_o[l] == 1'b1, "R7 error bit", lane_err_o[l], 1);
        check(r == 0, "R7 result zero", r, 0);
      end else begin
        check(lane_err_o[l] == 1'b0, "R6 no error", lane_err_o[l], 0);
        check(r == e, "R6 lock code", r, e);
      end
    end
    wait_cyc(3);
    check(done_o == 1'b1, "R8 done held", done_o, 1);
    check(rdy_o == 1'b0, "R10 ready low while done", rdy_o, 0);
    req_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R8 done cleared", done_o, 0);
    check(rdy_o == 1'b1, "R8 ready back", rdy_o, 1);
  endtask

  task automatic no_start(input logic [1:0] m, input logic ini, input string tag);
    mode_i = m; init_done_i = ini;
    pulse_cnt = 0; gap = 0; mon_on = 1;
    @(negedge clk);
    check(rdy_o == 1'b0, "R2 ready gated", rdy_o, 0);
    req_i = 1'b1;
    wait_cyc(40);
    mon_on = 0;
    check(pulse_cnt == 0, tag, pulse_cnt, 0);
    check(done_o == 1'b0, tag, done_o, 0);
    req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; cycles = 0; mon_on = 0;
    pulse_cnt = 0; gap = 0; cur_settle = 0;
    for (int l = 0; l < LANES; l++) begin glo[l] = 0; thr[l] = 10; end
    rst_n = 1'b0; init_done_i = 1'b0; mode_i = 2'b00; req_i = 1'b0; settle_i = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check(rdy_o == 1'b0 && done_o == 1'b0 && dqs_pulse_o == 1'b0, "R1 flags", {rdy_o, done_o, dqs_pulse_o}, 0);
    check(lane_err_o == '0, "R1 errors", int'(lane_err_o), 0);
    check(lane_dly_o == '0 && trial_dly_o == '0, "R1 results", int'(trial_dly_o), 0);

    no_start(2'b01, 1'b0, "R3 init not done");
    no_start(2'b11, 1'b1, "R3 read leveling mode");
    no_start(2'b10, 1'b1, "R3 gate leveling mode");
    no_start(2'b00, 1'b1, "R3 mode zero");

    // directed: clean step, leading ones, all ones, all zeros, step at last code
    glo[0] = 0; thr[0] = 7;
    glo[1] = 3; thr[1] = 9;
    glo[2] = 5; thr[2] = 5;
    glo[3] = 0; thr[3] = NCODE + 2;
    glo[4] = 0; thr[4] = NCODE - 1;
    glo[5] = 0; thr[5] = 1;
    glo[6] = 1; thr[6] = 2;
    glo[7] = 0; thr[7] = 0;
    glo[8] = 2; thr[8] = 20;
    run_once(0, 1'b0);
    run_once(4, 1'b1);

    for (int i = 0; i < 12; i++) begin
      set_lanes_random();
      run_once(int'($urandom % 7), (i % 4) == 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule